// File: doc/BRIEF.md
# Power Detector Sample Averager

The block turns one 32-bit snapshot of transmit power detector readings into a single averaged figure. The word carries four 8-bit samples, one per byte lane. If any lane holds zero or the full-scale marker, the snapshot is rejected as a whole. Otherwise the four samples are averaged with rounding to nearest, and a clear pattern is produced so that the slot can be marked as consumed.

A select input chooses between two paths. The CCK path averages the raw bytes. The OFDM path first shifts each byte by a fixed offset and wraps it into 6 bits. It then optionally takes a saturating boost correction off the average.

A caller pulses the start strobe with the word and the path controls. One cycle later the block pulses its result strobe. With that strobe it presents either an average or an invalid flag, and on an accepted snapshot it also presents a write-back strobe and the clear pattern.

Top module: `pwrdet_averager`

## Requirements
- R1: After reset, and before any start strobe, outValid, invalidOut, wbStrobe, avgOut and wbWord are all zero.
- R2: outValid is high in exactly the cycle that follows a cycle with startIn high, and low otherwise. Back-to-back starts give back-to-back results.
- R3: Byte lanes are wordIn[7:0], [15:8], [23:16] and [31:24]. If any lane equals zero, the result has invalidOut=1 and avgOut=0, on either path.
- R4: If any lane equals the full-scale marker (default 8'h7F), the result has invalidOut=1 and avgOut=0, on either path.
- R5: With ofdmSel=0 and all lanes valid, avgOut equals (a+b+c+d+2)>>2 of the raw unsigned bytes, which rounds halves upward.
- R6: With ofdmSel=1, each lane is replaced by (byte+32) mod 64 before the rounded average of R5 is taken.
- R7: With ofdmSel=1 and boostEn=1, 13 is subtracted from the OFDM average, and the result is 0 when the average is below 13.
- R8: With ofdmSel=0, boostEn has no effect on avgOut.
- R9: On an accepted snapshot, wbStrobe pulses with outValid and wbWord is the marker in every byte (default 32'h7F7F7F7F). On a rejected snapshot, wbStrobe stays low and wbWord is zero.
- R10: While startIn is low, avgOut, invalidOut and wbWord keep the values of the last result, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Single-cycle request: sample wordIn and the controls |
| wordIn | input | 32 | Four packed detector samples |
| ofdmSel | input | 1 | 1 selects the OFDM path, 0 the CCK path |
| boostEn | input | 1 | Apply the boost correction (OFDM path only) |
| outValid | output | 1 | Result strobe, one cycle after startIn |
| avgOut | output | 8 | Rounded, corrected average; zero when invalid |
| invalidOut | output | 1 | Snapshot was rejected |
| wbStrobe | output | 1 | Write the clear pattern back to the slot |
| wbWord | output | 32 | Clear pattern to write back |

## Verification
Every result is due exactly one clock edge after the edge that sees startIn high. The bench raises startIn on a falling edge and samples all outputs on the next falling edge, halfway through the result cycle. It then looks again one falling edge later to confirm that the strobes have dropped and that the held values have not moved. The back-to-back case keeps startIn high over two edges and reads the two results on the two falling edges that follow.

// File: rtl/pwrdet_pkg.sv
`timescale 1ns/1ps
package pwrdet_pkg;

  // Strobes from control to datapath for one request cycle.
  typedef struct packed {
    logic load;    // register a new result
    logic accept;  // snapshot valid: emit clear pattern
  } ctrlStrobe_t;

endpackage

// File: rtl/pwrdet_ctrl.sv
`timescale 1ns/1ps
module pwrdet_ctrl
  import pwrdet_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        allValid,
  output ctrlStrobe_t strobes,
  output logic        outValid,
  output logic        wbStrobe
);

  always_comb begin
    strobes.load   = startIn;
    strobes.accept = startIn && allValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wbStrobe <= 1'b0;
    end else begin
      outValid <= strobes.load;
      wbStrobe <= strobes.accept;
    end
  end

endmodule

// File: rtl/pwrdet_datapath.sv
`timescale 1ns/1ps
module pwrdet_datapath
  import pwrdet_pkg::*;
#(
  parameter int                  SAMPLE_W    = 8,
  parameter int                  NUM_SAMPLES = 4,
  parameter logic [SAMPLE_W-1:0] FULL_SCALE  = 8'h7F,
  parameter int                  OFDM_OFFSET = 32,
  parameter int                  OFDM_BITS   = 6,
  parameter int                  BOOST_SUB   = 13
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [SAMPLE_W*NUM_SAMPLES-1:0] wordIn,
  input  logic                            ofdmSel,
  input  logic                            boostEn,
  input  ctrlStrobe_t                     strobes,
  output logic                            allValid,
  output logic [SAMPLE_W-1:0]             avgOut,
  output logic                            invalidOut,
  output logic [SAMPLE_W*NUM_SAMPLES-1:0] wbWord
);

  localparam int WORD_W = SAMPLE_W * NUM_SAMPLES;
  localparam int SHIFT  = $clog2(NUM_SAMPLES);
  localparam int SUM_W  = SAMPLE_W + SHIFT + 1;
  localparam logic [SUM_W-1:0]    ROUND_ADD = SUM_W'(NUM_SAMPLES / 2);
  localparam logic [SAMPLE_W-1:0] OFFSET_V  = SAMPLE_W'(OFDM_OFFSET);
  localparam logic [SAMPLE_W-1:0] BOOST_V   = SAMPLE_W'(BOOST_SUB);

  logic [NUM_SAMPLES-1:0] laneOk;
  logic [SAMPLE_W-1:0]    laneVal [NUM_SAMPLES];

  for (genvar g = 0; g < NUM_SAMPLES; g++) begin : gLane
    logic [SAMPLE_W-1:0] rawByte;
    logic [SAMPLE_W-1:0] shifted;
    always_comb begin
      rawByte    = wordIn[g*SAMPLE_W +: SAMPLE_W];
      shifted    = rawByte + OFFSET_V;
      laneOk[g]  = (rawByte != '0) && (rawByte != FULL_SCALE);
      laneVal[g] = ofdmSel ? SAMPLE_W'(shifted[OFDM_BITS-1:0]) : rawByte;
    end
  end

  logic [SUM_W-1:0]    laneSum;
  logic [SAMPLE_W-1:0] meanVal;
  logic [SAMPLE_W-1:0] finalVal;

  always_comb begin
    laneSum = ROUND_ADD;
    for (int i = 0; i < NUM_SAMPLES; i++) begin
      laneSum = laneSum + SUM_W'(laneVal[i]);
    end
    meanVal  = SAMPLE_W'(laneSum >> SHIFT);
    allValid = &laneOk;
    if (ofdmSel && boostEn) begin
      finalVal = (meanVal >= BOOST_V) ? (meanVal - BOOST_V) : '0;
    end else begin
      finalVal = meanVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avgOut     <= '0;
      invalidOut <= 1'b0;
      wbWord     <= '0;
    end else if (strobes.load) begin
      invalidOut <= !allValid;
      avgOut     <= allValid ? finalVal : '0;
      wbWord     <= strobes.accept ? {NUM_SAMPLES{FULL_SCALE}} : WORD_W'(0);
    end
  end

endmodule

// File: rtl/pwrdet_averager.sv
`timescale 1ns/1ps
module pwrdet_averager
  import pwrdet_pkg::*;
#(
  parameter int                  SAMPLE_W    = 8,
  parameter int                  NUM_SAMPLES = 4,
  parameter logic [SAMPLE_W-1:0] FULL_SCALE  = 8'h7F,
  parameter int                  OFDM_OFFSET = 32,
  parameter int                  OFDM_BITS   = 6,
  parameter int                  BOOST_SUB   = 13
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            startIn,
  input  logic [SAMPLE_W*NUM_SAMPLES-1:0] wordIn,
  input  logic                            ofdmSel,
  input  logic                            boostEn,
  output logic                            outValid,
  output logic [SAMPLE_W-1:0]             avgOut,
  output logic                            invalidOut,
  output logic                            wbStrobe,
  output logic [SAMPLE_W*NUM_SAMPLES-1:0] wbWord
);

  ctrlStrobe_t strobes;
  logic        allValid;

  pwrdet_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .allValid (allValid),
    .strobes  (strobes),
    .outValid (outValid),
    .wbStrobe (wbStrobe)
  );

  pwrdet_datapath #(
    .SAMPLE_W    (SAMPLE_W),
    .NUM_SAMPLES (NUM_SAMPLES),
    .FULL_SCALE  (FULL_SCALE),
    .OFDM_OFFSET (OFDM_OFFSET),
    .OFDM_BITS   (OFDM_BITS),
    .BOOST_SUB   (BOOST_SUB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wordIn     (wordIn),
    .ofdmSel    (ofdmSel),
    .boostEn    (boostEn),
    .strobes    (strobes),
    .allValid   (allValid),
    .avgOut     (avgOut),
    .invalidOut (invalidOut),
    .wbWord     (wbWord)
  );

endmodule

// File: rtl/pwrdet_checks.sv
`timescale 1ns/1ps
module pwrdet_checks #(
  parameter int                  SAMPLE_W    = 8,
  parameter int                  NUM_SAMPLES = 4,
  parameter logic [SAMPLE_W-1:0] FULL_SCALE  = 8'h7F
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            startIn,
  input logic [SAMPLE_W*NUM_SAMPLES-1:0] wordIn,
  input logic                            outValid,
  input logic [SAMPLE_W-1:0]             avgOut,
  input logic                            invalidOut,
  input logic                            wbStrobe,
  input logic [SAMPLE_W*NUM_SAMPLES-1:0] wbWord
);

  logic anyZero;
  logic anyFull;
  always_comb begin
    anyZero = 1'b0;
    anyFull = 1'b0;
    for (int i = 0; i < NUM_SAMPLES; i++) begin
      if (wordIn[i*SAMPLE_W +: SAMPLE_W] == '0)        anyZero = 1'b1;
      if (wordIn[i*SAMPLE_W +: SAMPLE_W] == FULL_SCALE) anyFull = 1'b1;
    end
  end

  assert_result_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> outValid);

  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !outValid);

  assert_zero_lane_invalid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && anyZero) |=> (invalidOut && avgOut == '0 && !wbStrobe));

  assert_fullscale_lane_invalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && anyFull) |=> (invalidOut && avgOut == '0 && !wbStrobe));

  assert_writeback_pattern_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbStrobe |-> (outValid && !invalidOut && wbWord == {NUM_SAMPLES{FULL_SCALE}}));

  assert_accept_writes_back_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !invalidOut) |-> wbStrobe);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> ($stable(avgOut) && $stable(invalidOut) && $stable(wbWord)));

endmodule

bind pwrdet_averager pwrdet_checks #(
  .SAMPLE_W    (SAMPLE_W),
  .NUM_SAMPLES (NUM_SAMPLES),
  .FULL_SCALE  (FULL_SCALE)
) u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .startIn    (startIn),
  .wordIn     (wordIn),
  .outValid   (outValid),
  .avgOut     (avgOut),
  .invalidOut (invalidOut),
  .wbStrobe   (wbStrobe),
  .wbWord     (wbWord)
);

// File: tb/test_pwrdet_averager.sv
`timescale 1ns/1ps
module test_pwrdet_averager;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] wordIn = '0;
  logic        ofdmSel = 1'b0;
  logic        boostEn = 1'b0;
  logic        outValid;
  logic [7:0]  avgOut;
  logic        invalidOut;
  logic        wbStrobe;
  logic [31:0] wbWord;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [31:0] CLEAR = 32'h7F7F7F7F;

  always #2 clk = ~clk;

  pwrdet_averager i_pwrdet_averager (
    .clk(clk), .rstN(rstN), .startIn(startIn), .wordIn(wordIn),
    .ofdmSel(ofdmSel), .boostEn(boostEn), .outValid(outValid),
    .avgOut(avgOut), .invalidOut(invalidOut), .wbStrobe(wbStrobe),
    .wbWord(wbWord)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        ofdm;
    logic        boost;
    logic [7:0]  avg;
    logic        inv;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h04030201, 1'b0, 1'b0, 8'd3,   1'b0},  // R5 basic
    '{32'h02010101, 1'b0, 1'b0, 8'd1,   1'b0},  // R5 7/4 rounds down
    '{32'h02020101, 1'b0, 1'b0, 8'd2,   1'b0},  // R5 half rounds up
    '{32'h7E7E7E7E, 1'b0, 1'b0, 8'd126, 1'b0},  // R5 just below marker
    '{32'hFFFFFFFF, 1'b0, 1'b0, 8'd255, 1'b0},  // R5 largest sum
    '{32'h41302010, 1'b0, 1'b0, 8'd40,  1'b0},  // R5 mixed lanes
    '{32'h04030201, 1'b0, 1'b1, 8'd3,   1'b0},  // R8 boost ignored on CCK
    '{32'h04030201, 1'b1, 1'b0, 8'd35,  1'b0},  // R6 offset
    '{32'hFFFFFFFF, 1'b1, 1'b0, 8'd31,  1'b0},  // R6 wrap to 6 bits
    '{32'h04030201, 1'b1, 1'b1, 8'd22,  1'b0},  // R7 35-13
    '{32'h23222120, 1'b1, 1'b1, 8'd0,   1'b0},  // R7 saturate (avg 2)
    '{32'h2D2D2D2D, 1'b1, 1'b1, 8'd0,   1'b0},  // R7 avg exactly 13
    '{32'h2E2E2E2E, 1'b1, 1'b1, 8'd1,   1'b0},  // R7 avg 14
    '{32'h04030200, 1'b0, 1'b0, 8'd0,   1'b1},  // R3 lane 0 zero
    '{32'h00030201, 1'b1, 1'b1, 8'd0,   1'b1},  // R3 lane 3 zero, OFDM
    '{32'h7F030201, 1'b0, 1'b0, 8'd0,   1'b1},  // R4 lane 3 marker
    '{32'h02037F01, 1'b1, 1'b0, 8'd0,   1'b1}   // R4 lane 1 marker, OFDM
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkResult(input vec_t v, input string req);
    check(outValid === 1'b1, "R2", "outValid", 32'(outValid), 32'd1);
    check(invalidOut === v.inv, req, "invalidOut", 32'(invalidOut), 32'(v.inv));
    check(avgOut === v.avg, req, "avgOut", 32'(avgOut), 32'(v.avg));
    check(wbStrobe === !v.inv, "R9", "wbStrobe", 32'(wbStrobe), 32'(!v.inv));
    check(wbWord === (v.inv ? 32'h0 : CLEAR), "R9", "wbWord", wbWord,
          v.inv ? 32'h0 : CLEAR);
  endtask

  task automatic drive(input vec_t v);
    wordIn  = v.word;
    ofdmSel = v.ofdm;
    boostEn = v.boost;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(outValid === 1'b0 && wbStrobe === 1'b0 && invalidOut === 1'b0, "R1",
          "strobes", {29'd0, outValid, wbStrobe, invalidOut}, 32'd0);
    check(avgOut === 8'd0 && wbWord === 32'd0, "R1", "data",
          {avgOut, wbWord[23:0]}, 32'd0);

    // Table walk: each vector one request, then an idle cycle.
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      startIn = 1'b1;
      @(negedge clk);
      startIn = 1'b0;
      checkResult(VECS[k], VECS[k].inv ? "R3/R4" : "R5/R6/R7/R8");
      // R10: disturb inputs while idle; results must hold.
      wordIn  = 32'h00000000;
      ofdmSel = ~VECS[k].ofdm;
      boostEn = ~VECS[k].boost;
      @(negedge clk);
      check(outValid === 1'b0 && wbStrobe === 1'b0, "R2", "strobes drop",
            {30'd0, outValid, wbStrobe}, 32'd0);
      check(avgOut === VECS[k].avg && invalidOut === VECS[k].inv, "R10",
            "hold", {23'd0, invalidOut, avgOut}, {23'd0, VECS[k].inv, VECS[k].avg});
    end

    // R2 back-to-back requests
    drive(VECS[7]);
    startIn = 1'b1;
    @(negedge clk);
    checkResult(VECS[7], "R6");
    drive(VECS[15]);
    @(negedge clk);
    startIn = 1'b0;
    checkResult(VECS[15], "R4");
    @(negedge clk);
    check(outValid === 1'b0, "R2", "after burst", 32'(outValid), 32'd0);
    check(wbWord === 32'h0, "R9", "wbWord after reject hold", wbWord, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule